// File: doc/BRIEF.md
# Serial Audio Control Register Receiver

This block takes command frames from a three-wire serial link (enable, clock, data) and turns them into the control settings of an audio volume, tone and input-selector datapath. The three wires are oversampled by the system clock through a synchronizer. While the enable wire is high, each rising serial clock edge shifts one data bit, least significant bit first, into a 48-bit shadow register. The first 8 bits are the device address and the remaining 40 are the command payload.

A frame takes effect only when the enable wire falls. The shadow register must then hold exactly 48 bits, match the device address and carry a legal payload. The active register then loads in a single cycle, so the analog switches never see a half-written setting. Rejected frames leave every output as it was. A single attenuation code in each frame goes to the front and rear volume of whichever sides the frame enables, so balance is set by addressing one side at a time.

Top module: `audio_ctl_rx`

## Requirements
- R1: After reset, all four volume outputs read 80 (the mute code) and every other output reads 0.
- R2: While `ser_en` is high, each rising `ser_clk` edge takes one `ser_dat` bit, first bit = bit 0. Bits 0..7 form the address and bits 8..47 form payload bits P0..P39. Outputs update within 8 clock cycles after `ser_en` falls.
- R3: A frame whose address is not 8'h41 (bit 0 received first) leaves every output unchanged.
- R4: A frame that holds fewer or more than 48 bits when `ser_en` falls leaves every output unchanged.
- R5: The payload test bit P39 must be 0. A frame with P39 set leaves every output unchanged.
- R6: Equalizer band k (k = 0..4) sits in P[4k+3:4k], with legal codes 0..10. The left input select is P22..P20 and the right is P25..P23, with legal codes 0..4. A frame with any illegal band or select code leaves every output unchanged.
- R7: The attenuation code is P34..P28, where 0..79 means that many dB down. Any code of 80 or above is stored as 80 (mute).
- R8: P36 enables the left front and rear volume and P35 enables the right front and rear volume. A side whose bit is 0 keeps its volumes.
- R9: An accepted frame always loads the input selects, the fifth-input switches (P26 left, P27 right), the five band codes and the two initial-setting flags (P37 to `init_a`, P38 to `init_b`).
- R10: Serial clock edges while `ser_en` is low neither shift data nor change any output.
- R11: Outputs hold their values during a frame, including after all 48 bits have arrived, until `ser_en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en | input | 1 | Serial enable, frame window while high |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data |
| sel_l | output | 3 | Left input select |
| sel_r | output | 3 | Right input select |
| in5_l | output | 1 | Left fifth-input switch |
| in5_r | output | 1 | Right fifth-input switch |
| eq_lvl | output | 5x4 | Band codes, band k at [k] |
| vol_lf | output | 7 | Left front attenuation |
| vol_lr | output | 7 | Left rear attenuation |
| vol_rf | output | 7 | Right front attenuation |
| vol_rr | output | 7 | Right rear attenuation |
| init_a | output | 1 | First initial-setting flag |
| init_b | output | 1 | Second initial-setting flag |

## Verification
The hardest case is a frame that is correct in every field but one. A single illegal band code, a single stray test bit, or a bit count off by one must throw away the other 39 good payload bits. Random frames draw each field mostly from its legal range and only sometimes from outside it, so many frames hit exactly one defect. Directed frames place 47 and 49 bits, band code 11 and select code 5 right next to their legal limits. A further directed frame holds the enable high after all 48 bits have arrived, to show that nothing commits early.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;
   localparam int unsigned ADDR_W_D   = 8;
   localparam int unsigned DATA_W_D   = 40;
   localparam int unsigned DEV_ADDR_D = 8'h41;
   localparam int unsigned N_BANDS_D  = 5;
   localparam int unsigned EQ_W_D     = 4;
   localparam int unsigned EQ_MAX_D   = 10;
   localparam int unsigned SEL_W_D    = 3;
   localparam int unsigned SEL_MAX_D  = 4;
   localparam int unsigned VOL_W_D    = 7;
   localparam int unsigned VOL_MUTE_D = 80;
   localparam int unsigned TEST_W_D   = 1;

   typedef enum logic [1:0] {
      SIG_DAT = 2'd0,
      SIG_CLK = 2'd1,
      SIG_EN  = 2'd2
   } ser_sig_e;
endpackage

// File: rtl/aud_ser_sync.sv
module aud_ser_sync #(
   parameter int unsigned N_SIG  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SIG-1:0] async_in,
   output logic [N_SIG-1:0] sync_out
);
   if (N_SIG < 1) begin : g_chk_n
      $error("aud_ser_sync: N_SIG must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign sync_out = async_in;
   end else begin : g_chain
      for (genvar s = 0; s < N_SIG; s++) begin : g_sig
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '0;
            else        ff <= {ff[STAGES-2:0], async_in[s]};
         end
         assign sync_out[s] = ff[STAGES-1];
      end
   end
endmodule

// File: rtl/aud_frame_shift.sv
module aud_frame_shift #(
   parameter int unsigned FRAME_W = 48,
   parameter int unsigned CNT_W   = $clog2(FRAME_W + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_s,
   input  logic               sclk_s,
   input  logic               dat_s,
   output logic [FRAME_W-1:0] shadow,
   output logic [CNT_W-1:0]   bit_cnt,
   output logic               en_fall
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

   if (FRAME_W < 2) begin : g_chk_w
      $error("aud_frame_shift: FRAME_W too small");
   end

   logic en_q, sclk_q;
   logic sclk_rise, en_rise;

   assign sclk_rise = en_s & sclk_s & ~sclk_q;
   assign en_rise   = en_s & ~en_q;
   assign en_fall   = en_q & ~en_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         sclk_q  <= 1'b0;
         bit_cnt <= '0;
         shadow  <= '0;
      end else begin
         en_q   <= en_s;
         sclk_q <= sclk_s;
         if (en_rise)
            bit_cnt <= sclk_rise ? CNT_W'(1) : '0;
         else if (sclk_rise && bit_cnt != CNT_SAT)
            bit_cnt <= bit_cnt + CNT_W'(1);
         if (sclk_rise)
            shadow <= {dat_s, shadow[FRAME_W-1:1]};
      end
   end
endmodule

// File: rtl/aud_cmd_decode.sv
module aud_cmd_decode #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 40,
   parameter int unsigned DEV_ADDR = 8'h41,
   parameter int unsigned N_BANDS  = 5,
   parameter int unsigned EQ_W     = 4,
   parameter int unsigned EQ_MAX   = 10,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned SEL_MAX  = 4,
   parameter int unsigned VOL_W    = 7,
   parameter int unsigned VOL_MUTE = 80,
   parameter int unsigned TEST_W   = 1,
   parameter bit          SAT_VOL  = 1'b1
) (
   input  logic [ADDR_W+DATA_W-1:0]     frame,
   output logic                         ok,
   output logic [SEL_W-1:0]             d_sel_l,
   output logic [SEL_W-1:0]             d_sel_r,
   output logic                         d_sw_l,
   output logic                         d_sw_r,
   output logic [N_BANDS-1:0][EQ_W-1:0] d_eq,
   output logic [VOL_W-1:0]             d_vol,
   output logic                         d_len,
   output logic                         d_ren,
   output logic                         d_ia,
   output logic                         d_ib
);
   localparam int unsigned EQ_LO   = 0;
   localparam int unsigned SELL_LO = EQ_LO + N_BANDS * EQ_W;
   localparam int unsigned SELR_LO = SELL_LO + SEL_W;
   localparam int unsigned SWL_B   = SELR_LO + SEL_W;
   localparam int unsigned SWR_B   = SWL_B + 1;
   localparam int unsigned VOL_LO  = SWR_B + 1;
   localparam int unsigned REN_B   = VOL_LO + VOL_W;
   localparam int unsigned LEN_B   = REN_B + 1;
   localparam int unsigned IA_B    = LEN_B + 1;
   localparam int unsigned IB_B    = IA_B + 1;
   localparam int unsigned TEST_LO = IB_B + 1;

   if (TEST_LO + TEST_W != DATA_W) begin : g_chk_layout
      $error("aud_cmd_decode: field layout does not fill DATA_W");
   end
   if (VOL_MUTE >= (1 << VOL_W) || EQ_MAX >= (1 << EQ_W) || SEL_MAX >= (1 << SEL_W)) begin : g_chk_codes
      $error("aud_cmd_decode: code limit exceeds field width");
   end

   logic [ADDR_W-1:0]  addr;
   logic [DATA_W-1:0]  data;
   logic [VOL_W-1:0]   vol_raw;
   logic [N_BANDS-1:0] band_ok;
   logic               vol_ok;

   assign addr = frame[ADDR_W-1:0];
   assign data = frame[ADDR_W +: DATA_W];

   for (genvar b = 0; b < N_BANDS; b++) begin : g_band
      assign d_eq[b]    = data[EQ_LO + b*EQ_W +: EQ_W];
      assign band_ok[b] = (d_eq[b] <= EQ_W'(EQ_MAX));
   end

   assign d_sel_l = data[SELL_LO +: SEL_W];
   assign d_sel_r = data[SELR_LO +: SEL_W];
   assign d_sw_l  = data[SWL_B];
   assign d_sw_r  = data[SWR_B];
   assign vol_raw = data[VOL_LO +: VOL_W];
   assign d_ren   = data[REN_B];
   assign d_len   = data[LEN_B];
   assign d_ia    = data[IA_B];
   assign d_ib    = data[IB_B];

   if (SAT_VOL) begin : g_vol_sat
      assign d_vol  = (vol_raw >= VOL_W'(VOL_MUTE)) ? VOL_W'(VOL_MUTE) : vol_raw;
      assign vol_ok = 1'b1;
   end else begin : g_vol_strict
      assign d_vol  = vol_raw;
      assign vol_ok = (vol_raw <= VOL_W'(VOL_MUTE));
   end

   assign ok = (addr == ADDR_W'(DEV_ADDR))
             && (data[TEST_LO +: TEST_W] == '0)
             && (&band_ok)
             && (d_sel_l <= SEL_W'(SEL_MAX))
             && (d_sel_r <= SEL_W'(SEL_MAX))
             && vol_ok;
endmodule

// File: rtl/aud_ctl_regs.sv
module aud_ctl_regs #(
   parameter int unsigned N_BANDS  = 5,
   parameter int unsigned EQ_W     = 4,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned VOL_W    = 7,
   parameter int unsigned VOL_MUTE = 80
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         commit,
   input  logic                         upd_l,
   input  logic                         upd_r,
   input  logic [SEL_W-1:0]             n_sel_l,
   input  logic [SEL_W-1:0]             n_sel_r,
   input  logic                         n_sw_l,
   input  logic                         n_sw_r,
   input  logic [N_BANDS-1:0][EQ_W-1:0] n_eq,
   input  logic [VOL_W-1:0]             n_vol,
   input  logic                         n_ia,
   input  logic                         n_ib,
   output logic [SEL_W-1:0]             sel_l,
   output logic [SEL_W-1:0]             sel_r,
   output logic                         in5_l,
   output logic                         in5_r,
   output logic [N_BANDS-1:0][EQ_W-1:0] eq_lvl,
   output logic [VOL_W-1:0]             vol_lf,
   output logic [VOL_W-1:0]             vol_lr,
   output logic [VOL_W-1:0]             vol_rf,
   output logic [VOL_W-1:0]             vol_rr,
   output logic                         init_a,
   output logic                         init_b
);
   localparam logic [VOL_W-1:0] MUTE = VOL_W'(VOL_MUTE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_l  <= '0;
         sel_r  <= '0;
         in5_l  <= 1'b0;
         in5_r  <= 1'b0;
         eq_lvl <= '0;
         init_a <= 1'b0;
         init_b <= 1'b0;
      end else if (commit) begin
         sel_l  <= n_sel_l;
         sel_r  <= n_sel_r;
         in5_l  <= n_sw_l;
         in5_r  <= n_sw_r;
         eq_lvl <= n_eq;
         init_a <= n_ia;
         init_b <= n_ib;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vol_lf <= MUTE;
         vol_lr <= MUTE;
      end else if (commit && upd_l) begin
         vol_lf <= n_vol;
         vol_lr <= n_vol;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vol_rf <= MUTE;
         vol_rr <= MUTE;
      end else if (commit && upd_r) begin
         vol_rf <= n_vol;
         vol_rr <= n_vol;
      end
   end
endmodule

// File: rtl/audio_ctl_rx.sv
module audio_ctl_rx
   import audio_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W      = ADDR_W_D,
   parameter int unsigned DATA_W      = DATA_W_D,
   parameter int unsigned DEV_ADDR    = DEV_ADDR_D,
   parameter int unsigned N_BANDS     = N_BANDS_D,
   parameter int unsigned EQ_W        = EQ_W_D,
   parameter int unsigned EQ_MAX      = EQ_MAX_D,
   parameter int unsigned SEL_W       = SEL_W_D,
   parameter int unsigned SEL_MAX     = SEL_MAX_D,
   parameter int unsigned VOL_W       = VOL_W_D,
   parameter int unsigned VOL_MUTE    = VOL_MUTE_D,
   parameter int unsigned TEST_W      = TEST_W_D,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SAT_VOL     = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ser_en,
   input  logic                         ser_clk,
   input  logic                         ser_dat,
   output logic [SEL_W-1:0]             sel_l,
   output logic [SEL_W-1:0]             sel_r,
   output logic                         in5_l,
   output logic                         in5_r,
   output logic [N_BANDS-1:0][EQ_W-1:0] eq_lvl,
   output logic [VOL_W-1:0]             vol_lf,
   output logic [VOL_W-1:0]             vol_lr,
   output logic [VOL_W-1:0]             vol_rf,
   output logic [VOL_W-1:0]             vol_rr,
   output logic                         init_a,
   output logic                         init_b
);
   localparam int unsigned FRAME_W = ADDR_W + DATA_W;
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);

   if (SYNC_STAGES == 1) begin : g_chk_sync
      $error("audio_ctl_rx: SYNC_STAGES must be 0 or at least 2");
   end

   logic [2:0]               raw_in, sync_in;
   logic [FRAME_W-1:0]       shadow;
   logic [CNT_W-1:0]         bit_cnt;
   logic                     en_fall, frame_ok, commit;
   logic [SEL_W-1:0]         d_sel_l, d_sel_r;
   logic                     d_sw_l, d_sw_r, d_len, d_ren, d_ia, d_ib;
   logic [N_BANDS-1:0][EQ_W-1:0] d_eq;
   logic [VOL_W-1:0]         d_vol;
   logic [ADDR_W-1:0]        frame_addr;

   assign raw_in[SIG_DAT] = ser_dat;
   assign raw_in[SIG_CLK] = ser_clk;
   assign raw_in[SIG_EN]  = ser_en;

   aud_ser_sync #(.N_SIG(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(raw_in), .sync_out(sync_in)
   );

   aud_frame_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .en_s(sync_in[SIG_EN]), .sclk_s(sync_in[SIG_CLK]), .dat_s(sync_in[SIG_DAT]),
      .shadow(shadow), .bit_cnt(bit_cnt), .en_fall(en_fall)
   );

   aud_cmd_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR), .N_BANDS(N_BANDS),
      .EQ_W(EQ_W), .EQ_MAX(EQ_MAX), .SEL_W(SEL_W), .SEL_MAX(SEL_MAX),
      .VOL_W(VOL_W), .VOL_MUTE(VOL_MUTE), .TEST_W(TEST_W), .SAT_VOL(SAT_VOL)
   ) u_dec (
      .frame(shadow), .ok(frame_ok),
      .d_sel_l(d_sel_l), .d_sel_r(d_sel_r), .d_sw_l(d_sw_l), .d_sw_r(d_sw_r),
      .d_eq(d_eq), .d_vol(d_vol), .d_len(d_len), .d_ren(d_ren),
      .d_ia(d_ia), .d_ib(d_ib)
   );

   assign frame_addr = shadow[ADDR_W-1:0];
   assign commit     = en_fall && (bit_cnt == CNT_W'(FRAME_W)) && frame_ok;

   aud_ctl_regs #(
      .N_BANDS(N_BANDS), .EQ_W(EQ_W), .SEL_W(SEL_W), .VOL_W(VOL_W), .VOL_MUTE(VOL_MUTE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .commit(commit), .upd_l(d_len), .upd_r(d_ren),
      .n_sel_l(d_sel_l), .n_sel_r(d_sel_r), .n_sw_l(d_sw_l), .n_sw_r(d_sw_r),
      .n_eq(d_eq), .n_vol(d_vol), .n_ia(d_ia), .n_ib(d_ib),
      .sel_l(sel_l), .sel_r(sel_r), .in5_l(in5_l), .in5_r(in5_r),
      .eq_lvl(eq_lvl), .vol_lf(vol_lf), .vol_lr(vol_lr), .vol_rf(vol_rf),
      .vol_rr(vol_rr), .init_a(init_a), .init_b(init_b)
   );
endmodule

// File: rtl/audio_ctl_rx_chk.sv
module audio_ctl_rx_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DEV_ADDR = 8'h41,
   parameter int unsigned FRAME_W  = 48,
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned N_BANDS  = 5,
   parameter int unsigned EQ_W     = 4,
   parameter int unsigned EQ_MAX   = 10,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned SEL_MAX  = 4,
   parameter int unsigned VOL_W    = 7,
   parameter int unsigned VOL_MUTE = 80
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         commit,
   input logic                         en_fall,
   input logic                         upd_l,
   input logic                         upd_r,
   input logic [CNT_W-1:0]             bit_cnt,
   input logic [ADDR_W-1:0]            frame_addr,
   input logic [SEL_W-1:0]             sel_l,
   input logic [SEL_W-1:0]             sel_r,
   input logic                         in5_l,
   input logic                         in5_r,
   input logic [N_BANDS-1:0][EQ_W-1:0] eq_lvl,
   input logic [VOL_W-1:0]             vol_lf,
   input logic [VOL_W-1:0]             vol_lr,
   input logic [VOL_W-1:0]             vol_rf,
   input logic [VOL_W-1:0]             vol_rr,
   input logic                         init_a,
   input logic                         init_b
);
   localparam int unsigned OUT_W = 2*SEL_W + 4 + N_BANDS*EQ_W + 4*VOL_W;
   logic [OUT_W-1:0] all_out;
   assign all_out = {sel_l, sel_r, in5_l, in5_r, eq_lvl, vol_lf, vol_lr, vol_rf, vol_rr, init_a, init_b};

   AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(all_out)); // R11

   AST_ADDR_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
      (en_fall && frame_addr != ADDR_W'(DEV_ADDR)) |=> $stable(all_out)); // R3

   AST_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (bit_cnt == CNT_W'(FRAME_W))); // R4

   AST_LEFT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !upd_l) |=> ($stable(vol_lf) && $stable(vol_lr))); // R8

   AST_RIGHT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !upd_r) |=> ($stable(vol_rf) && $stable(vol_rr))); // R8

   AST_VOL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (vol_lf <= VOL_W'(VOL_MUTE)) && (vol_lr <= VOL_W'(VOL_MUTE)) &&
      (vol_rf <= VOL_W'(VOL_MUTE)) && (vol_rr <= VOL_W'(VOL_MUTE))); // R7

   AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_l <= SEL_W'(SEL_MAX)) && (sel_r <= SEL_W'(SEL_MAX))); // R6

   for (genvar b = 0; b < N_BANDS; b++) begin : g_eq_chk
      AST_EQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         eq_lvl[b] <= EQ_W'(EQ_MAX)); // R6
   end
endmodule

bind audio_ctl_rx audio_ctl_rx_chk #(
   .ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR), .FRAME_W(FRAME_W), .CNT_W(CNT_W),
   .N_BANDS(N_BANDS), .EQ_W(EQ_W), .EQ_MAX(EQ_MAX), .SEL_W(SEL_W),
   .SEL_MAX(SEL_MAX), .VOL_W(VOL_W), .VOL_MUTE(VOL_MUTE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .commit(commit), .en_fall(en_fall),
   .upd_l(d_len), .upd_r(d_ren), .bit_cnt(bit_cnt), .frame_addr(frame_addr),
   .sel_l(sel_l), .sel_r(sel_r), .in5_l(in5_l), .in5_r(in5_r), .eq_lvl(eq_lvl),
   .vol_lf(vol_lf), .vol_lr(vol_lr), .vol_rf(vol_rf), .vol_rr(vol_rr),
   .init_a(init_a), .init_b(init_b)
);

// File: tb/sim_audio_ctl_rx.sv
module sim_audio_ctl_rx;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
   logic [2:0] sel_l, sel_r;
   logic in5_l, in5_r, init_a, init_b;
   logic [4:0][3:0] eq_lvl;
   logic [6:0] vol_lf, vol_lr, vol_rf, vol_rr;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 1'b0;

   logic [2:0] x_sel_l, x_sel_r;
   logic x_in5_l, x_in5_r, x_ia, x_ib;
   logic [4:0][3:0] x_eq;
   logic [6:0] x_lf, x_lr, x_rf, x_rr;

   always #10 clk = ~clk;

   audio_ctl_rx u0 (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .sel_l(sel_l), .sel_r(sel_r), .in5_l(in5_l), .in5_r(in5_r), .eq_lvl(eq_lvl),
      .vol_lf(vol_lf), .vol_lr(vol_lr), .vol_rf(vol_rf), .vol_rr(vol_rr),
      .init_a(init_a), .init_b(init_b)
   );

   function automatic logic [39:0] mk_pay(input logic [4:0][3:0] eq, input logic [2:0] sl,
         input logic [2:0] sr, input logic wl, input logic wr, input logic [6:0] vol,
         input logic ren, input logic len, input logic ia, input logic ib, input logic tst);
      logic [39:0] p;
      p = '0;
      for (int k = 0; k < 5; k++) p[4*k +: 4] = eq[k];
      p[22:20] = sl; p[25:23] = sr; p[26] = wl; p[27] = wr;
      p[34:28] = vol; p[35] = ren; p[36] = len; p[37] = ia; p[38] = ib; p[39] = tst;
      return p;
   endfunction

   task automatic model(input logic [47:0] f, input int nb);
      logic [39:0] p;
      logic good;
      logic [6:0] v;
      p = f[47:8];
      good = (nb == 48) && (f[7:0] == 8'h41) && !p[39] && (p[22:20] <= 4) && (p[25:23] <= 4);
      for (int k = 0; k < 5; k++) if (p[4*k +: 4] > 10) good = 1'b0;
      if (good) begin
         v = (p[34:28] >= 80) ? 7'd80 : p[34:28];
         for (int k = 0; k < 5; k++) x_eq[k] = p[4*k +: 4];
         x_sel_l = p[22:20]; x_sel_r = p[25:23]; x_in5_l = p[26]; x_in5_r = p[27];
         x_ia = p[37]; x_ib = p[38];
         if (p[36]) begin x_lf = v; x_lr = v; end
         if (p[35]) begin x_rf = v; x_rr = v; end
      end
   endtask

   task automatic check(input string req);
      logic [57:0] act, exp;
      act = {sel_l, sel_r, in5_l, in5_r, eq_lvl, vol_lf, vol_lr, vol_rf, vol_rr, init_a, init_b};
      exp = {x_sel_l, x_sel_r, x_in5_l, x_in5_r, x_eq, x_lf, x_lr, x_rf, x_rr, x_ia, x_ib};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [47:0] f, input int nb, input string req, input bit mid);
      ser_en = 1'b1; wt(5);
      for (int i = 0; i < nb; i++) begin
         ser_dat = (i < 48) ? f[i] : 1'b0;
         wt(5); ser_clk = 1'b1; wt(5); ser_clk = 1'b0;
      end
      wt(8);
      if (mid) check("R11");
      ser_en = 1'b0;
      wt(10);
      model(f, nb);
      check(req);
   endtask

   function automatic logic [47:0] fr(input logic [7:0] a, input logic [39:0] p);
      return {p, a};
   endfunction

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
         end
      end
   end

   initial begin
      logic [4:0][3:0] e;
      void'($urandom(32'd2024));
      x_sel_l = 0; x_sel_r = 0; x_in5_l = 0; x_in5_r = 0; x_ia = 0; x_ib = 0;
      x_eq = '0; x_lf = 80; x_lr = 80; x_rf = 80; x_rr = 80;
      wt(4); rst_n = 1'b1; wt(3);
      check("R1");

      e = {4'd1, 4'd2, 4'd3, 4'd4, 4'd5};
      send(fr(8'h41, mk_pay(e, 3'd2, 3'd3, 1, 0, 7'd10, 1, 1, 1, 0, 0)), 48, "R2 R9", 1'b1);
      e = {4'd9, 4'd8, 4'd7, 4'd6, 4'd0};
      send(fr(8'h82, mk_pay(e, 3'd1, 3'd1, 0, 1, 7'd3, 1, 1, 0, 1, 0)), 48, "R3", 1'b0);
      send(fr(8'h41, mk_pay(e, 3'd1, 3'd1, 0, 1, 7'd3, 1, 1, 0, 1, 0)), 47, "R4 short", 1'b0);
      send(fr(8'h41, mk_pay(e, 3'd1, 3'd1, 0, 1, 7'd3, 1, 1, 0, 1, 0)), 49, "R4 long", 1'b0);
      send(fr(8'h41, mk_pay(e, 3'd1, 3'd1, 0, 1, 7'd3, 1, 1, 0, 1, 1)), 48, "R5", 1'b0);
      send(fr(8'h41, mk_pay({4'd11, 4'd0, 4'd0, 4'd0, 4'd0}, 3'd1, 3'd1, 0, 1, 7'd3, 1, 1, 0, 1, 0)), 48, "R6 eq", 1'b0);
      send(fr(8'h41, mk_pay(e, 3'd1, 3'd5, 0, 1, 7'd3, 1, 1, 0, 1, 0)), 48, "R6 sel", 1'b0);
      send(fr(8'h41, mk_pay({5{4'd10}}, 3'd4, 3'd4, 1, 1, 7'd79, 1, 1, 1, 1, 0)), 48, "R6 limit", 1'b0);
      send(fr(8'h41, mk_pay(e, 3'd0, 3'd1, 0, 0, 7'd100, 1, 1, 0, 0, 0)), 48, "R7", 1'b0);
      send(fr(8'h41, mk_pay(e, 3'd0, 3'd1, 0, 0, 7'd20, 0, 1, 0, 0, 0)), 48, "R8 left", 1'b0);
      send(fr(8'h41, mk_pay(e, 3'd0, 3'd1, 0, 0, 7'd33, 1, 0, 0, 0, 0)), 48, "R8 right", 1'b0);
      send(fr(8'h41, mk_pay(e, 3'd3, 3'd2, 1, 0, 7'd5, 0, 0, 1, 0, 0)), 48, "R8 none R9", 1'b0);

      ser_dat = 1'b1;
      for (int i = 0; i < 48; i++) begin wt(5); ser_clk = 1'b1; wt(5); ser_clk = 1'b0; end
      wt(10);
      check("R10");

      for (int n = 0; n < 90; n++) begin
         logic [2:0] sl, sr;
         logic [7:0] a;
         int nb;
         for (int k = 0; k < 5; k++)
            e[k] = ($urandom % 12 == 0) ? 4'(11 + $urandom % 5) : 4'($urandom % 11);
         sl = ($urandom % 10 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
         sr = ($urandom % 10 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
         a  = ($urandom % 8 == 0) ? 8'($urandom) : 8'h41;
         nb = ($urandom % 10 == 0) ? (($urandom % 2 == 0) ? 47 : 49) : 48;
         send(fr(a, mk_pay(e, sl, sr, 1'($urandom), 1'($urandom), 7'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  ($urandom % 12 == 0))), nb, "R2 random", 1'b0);
      end

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule